// File: doc/BRIEF.md
# Lane-Partitioned Left Shifter

This block is a purely combinational logical left shifter for a 32-bit word. The word is viewed as four 8-bit lanes, and a 3-bit cut vector decides at run time where partition boundaries fall. Adjacent lanes are merged into partitions of 8, 16, 24 or 32 bits.

Each partition shifts its own slice of the data operand left, with zero fill. Bits never cross into a neighbouring partition. The shift amount for a partition comes from the 8-bit slice of the amount vector that sits in the partition's lowest lane. That amount is cut down to the number of bits the partition width needs.

A SIMD datapath uses the block to run one wide shift, or several narrower shifts, with a single piece of logic.

Top module: `lane_lshift`

## Requirements
- R1: `part_cut[i]` set places a partition boundary between lane i and lane i+1 (lane 0 holds bits 7:0, lane 3 holds bits 31:24); clear joins the two lanes.
- R2: With `part_cut` = 3'b000 the whole word shifts left by `amt_vec[4:0]`, and only the low 32 bits are kept.
- R3: A partition whose lowest lane is k takes its amount from `amt_vec[8k+7:8k]`. The amount-vector slices of its other lanes have no effect on the result.
- R4: The amount is reduced to its low 3 bits for an 8-bit partition, its low 4 bits for a 16-bit partition, and its low 5 bits for a 24-bit or 32-bit partition.
- R5: Each partition's result is its own operand slice shifted left and truncated to the partition width. No bit passes into another partition.
- R6: Vacated low-order positions of every partition read as zero.
- R7: A 24-bit partition with a reduced amount of 24 to 31 gives all zeros across its three lanes.
- R8: `res` depends only on the present `opnd`, `amt_vec` and `part_cut`, with no clock and no stored state.
- R9: With `part_cut` = 3'b111 the four lanes shift as four independent 8-bit values. Values 3'b001, 3'b010 and 3'b100 give the splits {8, 24}, {16, 16} and {24, 8}, listed from lane 0 upward.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd | input | 32 | Data operand, four 8-bit lanes |
| amt_vec | input | 32 | Per-lane shift-amount slices |
| part_cut | input | 3 | Boundary flags between adjacent lanes |
| res | output | 32 | Shifted result |

## Verification
The block holds no state, so a fault shows at once: a wrong result appears in the same evaluation as the inputs that trigger it. A faulty partition scan or a faulty amount mask shows up as bits leaking across a lane seam, or as a shift taken modulo the wrong width. These faults appear only under the cut patterns and amounts that reach the faulty path. For that reason, every cut value is driven with zero, maximum and over-range amounts, and with all-ones data, which makes any leaked bit visible.

// File: rtl/lane_lshift.sv
module lane_lshift #(
  parameter int LANE_W = 8,
  parameter int LANES  = 4,
  localparam int DW    = LANE_W * LANES,
  localparam int SHW   = $clog2(DW),
  localparam int W2    = 2 * DW
) (
  input  logic [DW-1:0]    opnd,
  input  logic [DW-1:0]    amt_vec,
  input  logic [LANES-2:0] part_cut,
  output logic [DW-1:0]    res
);

  function automatic int log2c(input int v);
    int r;
    r = 0;
    for (int i = 0; i < 16; i++)
      if ((1 << i) < v) r = i + 1;
    return r;
  endfunction

  logic [DW-1:0] res_c;
  logic [LANES-1:0] is_start;
  assign is_start = {part_cut, 1'b1};

  always_comb begin
    int e;
    int w;
    int nb;
    logic [SHW-1:0] amt;
    logic [W2-1:0]  wm;
    logic [W2-1:0]  seg;
    res_c = '0;
    e = 0; w = 0; nb = 0; amt = '0; wm = '0; seg = '0;
    for (int p = 0; p < LANES; p++) begin
      if (is_start[p]) begin
        e = LANES - 1;
        for (int k = LANES - 2; k >= 0; k--)
          if (k >= p && part_cut[k]) e = k;
        w   = LANE_W * (e - p + 1);
        nb  = log2c(w);
        amt = amt_vec[p*LANE_W +: SHW] & SHW'((1 << nb) - 1);
        wm  = (W2'(1) << w) - W2'(1);
        seg = ({{DW{1'b0}}, opnd} >> (p * LANE_W)) & wm;
        seg = (seg << amt) & wm;
        res_c = res_c | DW'(seg << (p * LANE_W));
      end
    end
  end

  assign res = res_c;

  always_comb begin
    if (opnd == '0)
      p_zero_in_r6: assert (res == '0) else $error("zero operand gave nonzero result");
  end

  for (genvar j = 0; j < LANES; j++) begin : g_chk
    always_comb begin
      if (is_start[j] && amt_vec[j*LANE_W +: SHW] == '0)
        p_hold_r3: assert (res[j*LANE_W +: LANE_W] == opnd[j*LANE_W +: LANE_W])
          else $error("zero-amount partition altered lane %0d", j);
      if (is_start[j] && amt_vec[j*LANE_W])
        p_fill_r6: assert (res[j*LANE_W] == 1'b0)
          else $error("odd shift left lane %0d bit 0 set", j);
      if ((&part_cut) && opnd[j*LANE_W +: LANE_W] == '0)
        p_no_leak_r5: assert (res[j*LANE_W +: LANE_W] == '0)
          else $error("bits leaked into lane %0d", j);
    end
  end

  logic unused_amt;
  assign unused_amt = ^amt_vec;

endmodule

// File: tb/lane_lshift_tb_top.sv
`timescale 1ns/1ps
module lane_lshift_tb_top;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic [31:0] opnd = '0;
  logic [31:0] amt_vec = '0;
  logic [2:0]  part_cut = '0;
  logic [31:0] res;

  lane_lshift dut_i (.opnd(opnd), .amt_vec(amt_vec), .part_cut(part_cut), .res(res));

  typedef struct { logic [31:0] exp; string tag; } item_t;
  item_t sb_q[$];

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  function automatic logic [31:0] ref_shift(input logic [31:0] a, input logic [31:0] b,
                                            input logic [2:0] c);
    logic [31:0] r;
    int lo;
    r = '0;
    lo = 0;
    for (int ln = 0; ln < 4; ln++) begin
      if (ln == 3 || c[ln]) begin
        int w;
        int amt;
        w   = (ln - lo + 1) * 8;
        amt = int'(b[lo*8 +: 8]);
        if (w == 8) amt = amt % 8;
        else if (w == 16) amt = amt % 16;
        else amt = amt % 32;
        for (int k = lo * 8; k <= ln * 8 + 7; k++) begin
          int src;
          src = k - amt;
          r[k] = (src >= lo * 8) ? a[src] : 1'b0;
        end
        lo = ln + 1;
      end
    end
    return r;
  endfunction

  task automatic check_now(input logic [31:0] exp, input string tag);
    checks++;
    if (res !== exp) begin
      fails++;
      $display("FAIL %s: res=%08h expected=%08h", tag, res, exp);
    end
  endtask

  task automatic drive(input logic [31:0] a, input logic [31:0] b, input logic [2:0] c,
                       input string tag);
    item_t it;
    @(negedge clk);
    opnd = a; amt_vec = b; part_cut = c;
    it.exp = ref_shift(a, b, c);
    it.tag = tag;
    sb_q.push_back(it);
  endtask

  always @(posedge clk) begin
    if (sb_q.size() > 0) begin
      item_t it;
      it = sb_q.pop_front();
      checks++;
      if (res !== it.exp) begin
        fails++;
        $display("FAIL %s: res=%08h expected=%08h", it.tag, res, it.exp);
      end
    end
  end

  initial begin
    #200000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: res=%08h expected=completion", res);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (2) @(posedge clk);
    rst = 1'b0;
    #1 check_now(32'h0, "R8 idle zero inputs");

    // R2 full-word shift
    drive(32'h8000_0001, 32'h0000_0001, 3'b000, "R2 shift by 1");
    drive(32'hFFFF_FFFF, 32'hFFFF_FFFF, 3'b000, "R2 amount 31");
    drive(32'h1234_5678, 32'h0000_0020, 3'b000, "R2 amount 32 masks to 0");
    // R3 other-lane slices ignored
    drive(32'h0000_00FF, 32'hFFFF_FF00, 3'b000, "R3 upper slices ignored");
    drive(32'hFFFF_FFFF, 32'h0303_0300, 3'b111, "R3 lane 0 amount 0");
    drive(32'hA5A5_A5A5, 32'hFF00_0004, 3'b010, "R3 lane 3 slice ignored");
    // R4 amount truncation
    drive(32'hFFFF_FFFF, 32'h0909_0909, 3'b111, "R4 8-bit 9->1");
    drive(32'hFFFF_FFFF, 32'h0011_0011, 3'b010, "R4 16-bit 17->1");
    drive(32'hFFFF_FFFF, 32'h2100_0021, 3'b100, "R4 24-bit 33->1 / 8-bit");
    // R7 24-bit over-range
    drive(32'hFFFF_FFFF, 32'h0000_0018, 3'b100, "R7 24-bit amount 24");
    drive(32'hFFFF_FFFF, 32'h0000_1F00, 3'b001, "R7 24-bit amount 31");
    // R5 / R6 / R9 / R1 patterns
    drive(32'hFFFF_FFFF, 32'h0707_0707, 3'b111, "R9 four lanes max");
    drive(32'h8080_8080, 32'h0101_0101, 3'b111, "R5 no carry across lanes");
    drive(32'hFFFF_FFFF, 32'h0000_0F0F, 3'b011, "R1 split 8/8/16");
    drive(32'hFFFF_FFFF, 32'h0F00_0007, 3'b101, "R1 split 8/16/8");
    drive(32'hFFFF_FFFF, 32'h0700_000F, 3'b110, "R1 split 16/8/8");
    drive(32'h0000_0001, 32'h0000_0004, 3'b001, "R6 zero fill 8/24");

    for (int c = 0; c < 8; c++) begin
      for (int n = 0; n < 30; n++) begin
        logic [31:0] ra;
        logic [31:0] rb;
        ra = $urandom;
        rb = $urandom;
        if (n == 0) ra = 32'hFFFF_FFFF;
        drive(ra, rb, 3'(c), "R5 random partition");
      end
      drive(32'hFFFF_FFFF, 32'h0, 3'(c), "R6 amount zero");
      drive(32'hFFFF_FFFF, 32'hFFFF_FFFF, 3'(c), "R4 amount all ones");
    end

    // R8 immediate response
    @(negedge clk);
    opnd = 32'h0F0F_0F0F; amt_vec = 32'h0404_0404; part_cut = 3'b111;
    #1 check_now(32'hF0F0_F0F0, "R8 same-time response");
    opnd = 32'h0000_0001; amt_vec = 32'h0000_001F; part_cut = 3'b000;
    #1 check_now(32'h8000_0000, "R8 R2 same-time response");

    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule